// File: doc/BRIEF.md
# Predicated Vector Splice Unit

This datapath block merges two vector operands under a per-byte predicate mask. It finds the lowest and highest active elements of the predicate. It copies every element of the first operand between them, inactive ones included, into the low elements of the result. The upper result elements that remain are then filled from the bottom of the second operand.

The vector width is fixed when the block is built. The element width is chosen with each operation. One operation enters per cycle through a valid/ready handshake. The result leaves through a registered output stage that holds its data until the consumer takes it.

Top module: `vsplice_unit`

## Requirements
- R1: The 2-bit size code `in_size` selects an element width of 8 << size bits: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64. The vector holds VL divided by that width elements, and element e occupies bits [e*width +: width].
- R2: The predicate has one bit per byte, with bit k belonging to byte k. An element counts as active when the predicate bit of its lowest byte is set. The other predicate bits of that element have no effect on the result.
- R3: The copied span runs from the lowest-numbered active element of the first operand to the highest-numbered one, inclusive, and takes every element in between whether active or not. The span is written in order into the result starting at element 0.
- R4: The result elements above the span hold second-operand elements 0, 1, 2 and onward, until the result is full.
- R5: When no element is active, the result equals the second operand.
- R6: When exactly one element is active, that first-operand element is placed in result element 0. The result elements above it hold the second operand's low elements.
- R7: When every element is active, the result equals the first operand.
- R8: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. The result and `out_valid` appear in the cycle after acceptance and stay unchanged until `out_ready` is high.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_size | input | 2 | Element size code |
| in_src_a | input | VL | First operand, the source of the span |
| in_src_b | input | VL | Second operand, the source of the fill |
| in_pred | input | VL/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VL | Spliced result |

## Verification
On every cycle, the assertions check the handshake: data held stable under back-pressure, a result following each acceptance, and ready dropping while a result is stalled. They also check the two predicate extremes, where an empty mask passes the second operand through and a full mask passes the first operand through. Span placement for partial masks needs a reference model, so only the bench's scenarios show it. The same holds for the inclusion of inactive elements inside the span, for the ignored non-leading predicate bits of wide elements, and for the per-size element boundaries.

// File: rtl/vsplice_unit.sv
module vsplice_unit #(
  parameter int VL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_size,
  input  logic [VL-1:0]     in_src_a,
  input  logic [VL-1:0]     in_src_b,
  input  logic [VL/8-1:0]   in_pred,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VL-1:0]     out_data
);
  localparam int NB = VL / 8;
  localparam int IW = $clog2(NB) + 1;

  logic [2:0]    lane_mask;
  logic [NB-1:0] lead_pred;
  logic [NB-1:0] keep_a;
  logic [IW-1:0] first_b, last_b, span_b, elem_b;
  logic          any_act;
  logic [VL-1:0] a_part, b_part, spliced;

  always_comb begin
    case (in_size)
      2'd0:    lane_mask = 3'd0;
      2'd1:    lane_mask = 3'd1;
      2'd2:    lane_mask = 3'd3;
      default: lane_mask = 3'd7;
    endcase
  end

  assign elem_b = IW'(lane_mask) + IW'(1);

  for (genvar gb = 0; gb < NB; gb++) begin : g_lead
    assign lead_pred[gb] = in_pred[gb] && ((3'(gb) & lane_mask) == 3'd0);
  end

  always_comb begin
    first_b = '0;
    last_b  = '0;
    for (int b = NB - 1; b >= 0; b--)
      if (lead_pred[b]) first_b = IW'(b);
    for (int b = 0; b < NB; b++)
      if (lead_pred[b]) last_b = IW'(b);
  end

  assign any_act = |lead_pred;
  assign span_b  = any_act ? (last_b - first_b + elem_b) : '0;

  for (genvar gk = 0; gk < NB; gk++) begin : g_keep
    assign keep_a[gk] = IW'(gk) < span_b;
    assign a_part[gk*8 +: 8] = keep_a[gk] ? spliced_a_byte(gk) : 8'h00;
  end

  function automatic logic [7:0] spliced_a_byte(input int k);
    logic [VL-1:0] sh;
    sh = in_src_a >> {first_b, 3'b000};
    return sh[k*8 +: 8];
  endfunction

  assign b_part  = in_src_b << {span_b, 3'b000};
  assign spliced = a_part | b_part;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= spliced;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vsplice_unit_chk.sv
module vsplice_unit_chk #(
  parameter int VL = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_size,
  input logic [VL-1:0]   in_src_a,
  input logic [VL-1:0]   in_src_b,
  input logic [VL/8-1:0] in_pred,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VL-1:0]   out_data
);
  logic unused_sz;
  assign unused_sz = ^in_size;

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !in_valid |=> !out_valid);

  a_r5_empty_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_pred == '0 |=> out_data == $past(in_src_b));

  a_r7_full_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && &in_pred |=> out_data == $past(in_src_a));

  always @(posedge clk)
    if (!rst_n) a_r9_reset_idle: assert (!out_valid && in_ready);
endmodule

bind vsplice_unit vsplice_unit_chk #(.VL(VL)) u_chk (.*);

// File: tb/tb_vsplice_unit.sv
module tb_vsplice_unit;
  localparam int VL = 256;
  localparam int NB = VL / 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [1:0] in_size = 0;
  logic [VL-1:0] in_src_a = '0, in_src_b = '0;
  logic [NB-1:0] in_pred = '0;
  logic in_ready, out_valid;
  logic [VL-1:0] out_data;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  vsplice_unit #(.VL(VL)) dut (.*);

  function automatic logic [VL-1:0] ref_splice(input logic [VL-1:0] a, b,
      input logic [NB-1:0] p, input logic [1:0] sz);
    logic [VL-1:0] r;
    int eb, ne, lo, hi, x;
    eb = 1 << sz; ne = NB / eb; lo = -1; hi = -1; x = 0; r = '0;
    for (int e = 0; e < ne; e++)
      if (p[e*eb]) begin
        if (lo < 0) lo = e;
        hi = e;
      end
    if (lo >= 0)
      for (int e = lo; e <= hi; e++) begin
        for (int k = 0; k < eb; k++) r[(x*eb+k)*8 +: 8] = a[(e*eb+k)*8 +: 8];
        x++;
      end
    for (int e = 0; x < ne; e++) begin
      for (int k = 0; k < eb; k++) r[(x*eb+k)*8 +: 8] = b[(e*eb+k)*8 +: 8];
      x++;
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string req, input logic [VL-1:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] sz, input logic [NB-1:0] p);
    logic [VL-1:0] a, b;
    a = rnd_vec(); b = rnd_vec();
    @(negedge clk);
    in_size = sz; in_pred = p; in_src_a = a; in_src_b = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid"}, VL'(out_valid), VL'(1));
    chk(req, out_data, ref_splice(a, b, p, sz));
  endtask

  task automatic t_reset();
    chk("R9 out_valid", VL'(out_valid), VL'(0));
    chk("R9 in_ready", VL'(in_ready), VL'(1));
  endtask

  task automatic t_empty();
    for (int s = 0; s < 4; s++) run_op("R5 empty", 2'(s), '0);
  endtask

  task automatic t_full();
    for (int s = 0; s < 4; s++) run_op("R7 full", 2'(s), '1);
  endtask

  task automatic t_single();
    for (int s = 0; s < 4; s++) begin
      run_op("R6 single low", 2'(s), NB'(1));
      run_op("R6 single top", 2'(s), NB'(1) << (NB - (1 << s)));
      run_op("R6 single mid", 2'(s), NB'(1) << (8 & ~((1 << s) - 1)));
    end
  endtask

  task automatic t_sparse();
    for (int s = 0; s < 4; s++) begin
      run_op("R3 R4 sparse gap", 2'(s), NB'(1) << (1 << s) | NB'(1) << (4 << s));
      run_op("R1 R3 R4 two ends", 2'(s), NB'(1) | NB'(1) << (NB - (1 << s)));
    end
  endtask

  task automatic t_ignored();
    run_op("R2 non-lead bits only", 2'd2, {(NB/4){4'b1110}});
    run_op("R2 non-lead bits only", 2'd3, {(NB/8){8'b1111_1110}});
    run_op("R2 mixed lead bits", 2'd1, 32'h0000_06E4);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) run_op("R1 R3 R4 random", 2'($urandom), NB'({$urandom, $urandom}));
  endtask

  task automatic t_backpressure();
    logic [VL-1:0] a, b, held;
    a = rnd_vec(); b = rnd_vec();
    @(negedge clk);
    out_ready = 0; in_size = 2'd1; in_pred = 32'h0000_0F00; in_src_a = a; in_src_b = b; in_valid = 1;
    @(negedge clk);
    held = out_data;
    chk("R8 result valid", VL'(out_valid), VL'(1));
    chk("R8 ready low when stalled", VL'(in_ready), VL'(0));
    in_src_a = rnd_vec();
    repeat (3) @(negedge clk);
    chk("R8 held data", out_data, held);
    chk("R8 held data ref", out_data, ref_splice(a, b, 32'h0000_0F00, 2'd1));
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    chk("R8 drained", VL'(out_valid), VL'(0));
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_empty();
    t_full();
    t_single();
    t_sparse();
    t_ignored();
    t_random();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule